// File: doc/BRIEF.md
# Serial Interrupt Line Host Controller

This block runs the host end of a one-wire serial interrupt link that shares a single open-drain line with a set of peripherals. The link is clocked by the bus clock. The host opens each cycle with a low start pulse. It then walks through a fixed run of data frames, one frame per interrupt source. In the first clock of each frame it samples the line, and a low level means that the matching request is active. A stop pulse closes the cycle. The length of that stop pulse tells the peripherals whether the next cycle will be started by the host (continuous mode) or only on a peripheral's request (quiet mode).

The line is split into three signals: a drive enable, the value driven, and the sampled line level. A small set of control inputs sets the enable, the mode, the frame-size code and the start pulse width. The decoded request levels come out as a vector. They are updated only when a cycle finishes completely, so a cycle that is cut off by a disable never shows partial results.

Top module: `sirq_host`

## Requirements
- R1: While `cfg_en` is 0 the host never drives the line (`line_oe` = 0) and `irq_lvl` reads all zeros.
- R2: When `cfg_en` rises with `cfg_cont` = 1, the host drives the line low in the very next clock.
- R3: A host-started start pulse is driven low for 4, 6 or 8 clocks when `cfg_spw` is 00, 01 or 10 respectively.
- R4: The reserved width code `cfg_spw` = 11 gives a 4-clock start pulse.
- R5: Every driven-low pulse is followed by exactly one clock driven high, and then the line is released.
- R6: After the start pulse's high and release clocks come 17 data frames of 3 clocks each, and the host never drives during them. The line is sampled in the first clock of frame i, and a low sample sets bit i of `irq_lvl`, while a high sample clears it.
- R7: The stop pulse is driven low for 3 clocks when `cfg_cont` = 1 and for 2 clocks when `cfg_cont` = 0, using the value of `cfg_cont` at the end of the last data frame.
- R8: After a 3-clock stop pulse, the next start pulse begins in the clock right after the stop's release clock.
- R9: After a 2-clock stop pulse the host stays idle and undriven. When a peripheral pulls the line low for one clock, the host continues the pulse low for the configured width minus one clock.
- R10: `irq_lvl` takes the new sampled values one clock after the stop's release clock. A cycle that is aborted by clearing `cfg_en` leaves the previously committed values, which show again once the block is re-enabled.
- R11: `cfg_fsize` has no effect: every value gives the same 17-frame cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Enables the controller |
| cfg_cont | input | 1 | 1 = continuous mode, 0 = quiet mode |
| cfg_fsize | input | 4 | Frame-size code (all values treated as the 21-frame code) |
| cfg_spw | input | 2 | Start pulse width select |
| line_in | input | 1 | Sampled level of the serial line |
| line_oe | output | 1 | Host drive enable for the serial line |
| line_out | output | 1 | Value driven when `line_oe` is 1 |
| irq_lvl | output | 17 | Committed request levels, bit i for frame i, 1 = asserted |

## Verification
On every clock, the embedded properties check the following: the sequencer falls back to idle once the block is disabled; every high clock is followed by a release; a low start phase can only continue, turn high or abort; the data frame index stays in range; a 3-clock stop leads straight into a new start; and the committed vector changes only at cycle completion. The directed scenarios cover what depends on whole sequences seen at the pins. This includes the exact low widths for each width code, the sampling position inside the frames, and the stop lengths in each mode. It also covers the quiet-mode handoff from a peripheral-started pulse, the use of the frame-size code, and keeping the old levels across an aborted cycle.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START_LO,
    ST_START_HI,
    ST_START_TA,
    ST_SAMP,
    ST_RECOV,
    ST_TURN,
    ST_STOP_LO,
    ST_STOP_HI,
    ST_STOP_TA
  } sirq_state_e;

  // Total frames per cycle for the one supported size code, minus the
  // frames that are not data slots.
  localparam int FRAME_TOTAL    = 21;
  localparam int FRAME_OVERHEAD = 4;
  localparam int DATA_FRAMES    = FRAME_TOTAL - FRAME_OVERHEAD;

endpackage

// File: rtl/sirq_cfg.sv
module sirq_cfg #(
  parameter int CNT_W    = 4,
  parameter int PW_SHORT = 4,
  parameter int PW_MID   = 6,
  parameter int PW_LONG  = 8
) (
  input  logic [1:0]       spw,
  input  logic [3:0]       fsize,
  output logic [CNT_W-1:0] host_cnt,
  output logic [CNT_W-1:0] quiet_cnt
);

  logic [CNT_W-1:0] width;
  logic             unused_fsize;

  // Only one frame size is implemented; the code is accepted and ignored.
  assign unused_fsize = ^fsize;

  always_comb begin
    case (spw)
      2'b01:   width = CNT_W'(PW_MID);
      2'b10:   width = CNT_W'(PW_LONG);
      default: width = CNT_W'(PW_SHORT); // 00 and reserved 11
    endcase
  end

  // Counters count down to zero, so the preload is one below the clock count.
  assign host_cnt  = width - CNT_W'(1);
  // Peripheral already supplied the first low clock.
  assign quiet_cnt = width - CNT_W'(2);

endmodule

// File: rtl/sirq_fsm.sv
module sirq_fsm
  import sirq_pkg::*;
#(
  parameter int NFRM   = 17,
  parameter int CNT_W  = 4,
  parameter int SLOT_W = (NFRM > 1) ? $clog2(NFRM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cont,
  input  logic              line_in,
  input  logic [CNT_W-1:0]  host_cnt,
  input  logic [CNT_W-1:0]  quiet_cnt,
  output logic [SLOT_W-1:0] slot,
  output logic              drive_oe,
  output logic              drive_val,
  output logic              sample_en,
  output logic              commit
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NFRM - 1);
  localparam logic [CNT_W-1:0]  STOP_CONT = CNT_W'(2);
  localparam logic [CNT_W-1:0]  STOP_QUIET = CNT_W'(1);

  sirq_state_e       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              stopc_q, stopc_d;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    slot_d  = slot_q;
    stopc_d = stopc_q;
    if (!en) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (cont) begin
            state_d = ST_START_LO;
            cnt_d   = host_cnt;
          end else if (!line_in) begin
            state_d = ST_START_LO;
            cnt_d   = quiet_cnt;
          end
        end
        ST_START_LO: begin
          if (cnt_q == '0) state_d = ST_START_HI;
          else             cnt_d   = cnt_q - CNT_W'(1);
        end
        ST_START_HI: state_d = ST_START_TA;
        ST_START_TA: begin
          state_d = ST_SAMP;
          slot_d  = '0;
        end
        ST_SAMP:  state_d = ST_RECOV;
        ST_RECOV: state_d = ST_TURN;
        ST_TURN: begin
          if (slot_q == LAST_SLOT) begin
            state_d = ST_STOP_LO;
            cnt_d   = cont ? STOP_CONT : STOP_QUIET;
            stopc_d = cont;
          end else begin
            state_d = ST_SAMP;
            slot_d  = slot_q + SLOT_W'(1);
          end
        end
        ST_STOP_LO: begin
          if (cnt_q == '0) state_d = ST_STOP_HI;
          else             cnt_d   = cnt_q - CNT_W'(1);
        end
        ST_STOP_HI: state_d = ST_STOP_TA;
        ST_STOP_TA: begin
          if (stopc_q) begin
            state_d = ST_START_LO;
            cnt_d   = host_cnt;
          end else begin
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      slot_q  <= '0;
      stopc_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      slot_q  <= slot_d;
      stopc_q <= stopc_d;
    end
  end

  assign slot      = slot_q;
  assign drive_oe  = en && (state_q == ST_START_LO || state_q == ST_START_HI ||
                            state_q == ST_STOP_LO  || state_q == ST_STOP_HI);
  assign drive_val = (state_q == ST_START_HI) || (state_q == ST_STOP_HI);
  assign sample_en = en && (state_q == ST_SAMP);
  assign commit    = en && (state_q == ST_STOP_TA);

  // R1: a disabled controller returns to idle
  a_r1_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> state_q == ST_IDLE);

  // R5: a driven-high clock is always followed by release
  a_r5_high_release: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (state_q == ST_START_HI || state_q == ST_STOP_HI)) |=> !drive_oe);

  // R5: low start phase only continues, turns high, or aborts
  a_r5_low_then_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START_LO) |=>
      (state_q == ST_START_LO || state_q == ST_START_HI || state_q == ST_IDLE));

  // R6: data frame index never leaves the slot range
  a_r6_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SAMP) |-> slot_q <= LAST_SLOT);

  // R7: the last data frame leads into the stop pulse
  a_r7_stop_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q == ST_TURN && slot_q == LAST_SLOT) |=> state_q == ST_STOP_LO);

  // R8: a continuous-mode stop restarts at once
  a_r8_cont_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q == ST_STOP_TA && stopc_q) |=> state_q == ST_START_LO);

endmodule

// File: rtl/sirq_capture.sv
module sirq_capture #(
  parameter int NFRM   = 17,
  parameter int SLOT_W = (NFRM > 1) ? $clog2(NFRM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic [SLOT_W-1:0] slot,
  input  logic              line_in,
  input  logic              commit,
  output logic [NFRM-1:0]   held
);

  logic [NFRM-1:0] samp_q, samp_d;
  logic [NFRM-1:0] held_q, held_d;

  for (genvar i = 0; i < NFRM; i++) begin : g_slot
    // Low level on the line means the request is active.
    assign samp_d[i] = (sample_en && slot == SLOT_W'(i)) ? ~line_in : samp_q[i];
  end

  assign held_d = commit ? samp_q : held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      held_q <= '0;
    end else begin
      samp_q <= samp_d;
      held_q <= held_d;
    end
  end

  assign held = held_q;

  // R10: committed levels change only at cycle completion
  a_r10_hold_until_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(held_q));

endmodule

// File: rtl/sirq_host.sv
module sirq_host
  import sirq_pkg::*;
#(
  parameter int NFRM  = DATA_FRAMES,
  parameter int CNT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic            cfg_cont,
  input  logic [3:0]      cfg_fsize,
  input  logic [1:0]      cfg_spw,
  input  logic            line_in,
  output logic            line_oe,
  output logic            line_out,
  output logic [NFRM-1:0] irq_lvl
);

  localparam int SLOT_W = (NFRM > 1) ? $clog2(NFRM) : 1;

  logic [CNT_W-1:0]  host_cnt;
  logic [CNT_W-1:0]  quiet_cnt;
  logic [SLOT_W-1:0] slot;
  logic              sample_en;
  logic              commit;
  logic [NFRM-1:0]   held;

  sirq_cfg #(.CNT_W(CNT_W)) cfg_i (
    .spw       (cfg_spw),
    .fsize     (cfg_fsize),
    .host_cnt  (host_cnt),
    .quiet_cnt (quiet_cnt)
  );

  sirq_fsm #(.NFRM(NFRM), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_en),
    .cont      (cfg_cont),
    .line_in   (line_in),
    .host_cnt  (host_cnt),
    .quiet_cnt (quiet_cnt),
    .slot      (slot),
    .drive_oe  (line_oe),
    .drive_val (line_out),
    .sample_en (sample_en),
    .commit    (commit)
  );

  sirq_capture #(.NFRM(NFRM), .SLOT_W(SLOT_W)) cap_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .slot      (slot),
    .line_in   (line_in),
    .commit    (commit),
    .held      (held)
  );

  assign irq_lvl = cfg_en ? held : '0;

endmodule

// File: tb/sirq_host_tb.sv
module sirq_host_tb_top;

  localparam int NF = 17;

  logic          clk;
  logic          rst_n;
  logic          cfg_en;
  logic          cfg_cont;
  logic [3:0]    cfg_fsize;
  logic [1:0]    cfg_spw;
  logic          line_oe;
  logic          line_out;
  logic [NF-1:0] irq_lvl;
  logic          periph_low;
  logic          line_w;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Open-drain line with pull-up; host drive wins when enabled.
  assign line_w = line_oe ? line_out : ~periph_low;

  sirq_host dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .cfg_cont  (cfg_cont),
    .cfg_fsize (cfg_fsize),
    .cfg_spw   (cfg_spw),
    .line_in   (line_w),
    .line_oe   (line_oe),
    .line_out  (line_out),
    .irq_lvl   (irq_lvl)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Follows one full cycle from its start pulse onward, acting as the
  // peripherals; pattern bit i asserts request i.
  task automatic run_cycle(input int exp_low, input logic [NF-1:0] pat,
                           input int exp_stop, input logic [NF-1:0] exp_irq);
    int n;
    int bad;
    n = 0;
    while (!(line_oe && !line_out) && n < 60) begin n++; @(negedge clk); end
    n = 0;
    while (line_oe && !line_out && n < 20) begin n++; @(negedge clk); end
    chk(n == exp_low, "R3", "start pulse width", n, exp_low);
    chk(line_oe && line_out, "R5", "start high clock", {line_oe, line_out}, 3);
    @(negedge clk);
    chk(!line_oe, "R5", "start release", line_oe, 0);
    bad = 0;
    for (int i = 0; i < NF; i++) begin
      @(negedge clk);
      if (line_oe) bad++;
      periph_low = pat[i];
      @(negedge clk);
      periph_low = 1'b0;
      if (line_oe) bad++;
      @(negedge clk);
      if (line_oe) bad++;
    end
    chk(bad == 0, "R6", "host drove during data frames", bad, 0);
    @(negedge clk);
    n = 0;
    while (line_oe && !line_out && n < 20) begin n++; @(negedge clk); end
    chk(n == exp_stop, "R7", "stop pulse width", n, exp_stop);
    chk(line_oe && line_out, "R5", "stop high clock", {line_oe, line_out}, 3);
    @(negedge clk);
    chk(!line_oe, "R5", "stop release", line_oe, 0);
    @(negedge clk);
    chk(irq_lvl == exp_irq, "R10", "levels after cycle", int'(irq_lvl), int'(exp_irq));
  endtask

  task automatic set_off();
    @(negedge clk);
    cfg_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!line_oe, "R1", "oe after reset", line_oe, 0);
    chk(irq_lvl == '0, "R1", "irq after reset", int'(irq_lvl), 0);
  endtask

  task automatic t_enable_cont();
    cfg_spw  = 2'b00;
    cfg_cont = 1'b1;
    cfg_en   = 1'b1;
    @(negedge clk);
    chk(line_oe && !line_out, "R2", "low right after enable", {line_oe, line_out}, 2);
    run_cycle(4, 17'h0_A5C3, 3, 17'h0_A5C3);
    chk(line_oe && !line_out, "R8", "next start directly after stop",
        {line_oe, line_out}, 2);
    run_cycle(4, 17'h1_0001, 3, 17'h1_0001);
  endtask

  task automatic t_widths();
    set_off();
    cfg_spw = 2'b01; cfg_en = 1'b1;
    run_cycle(6, 17'h1_FFFF, 3, 17'h1_FFFF);
    set_off();
    cfg_spw = 2'b10; cfg_en = 1'b1;
    run_cycle(8, 17'h0_0000, 3, 17'h0_0000);
    set_off();
    // R4 reserved width code, R11 odd frame-size code
    cfg_spw = 2'b11; cfg_fsize = 4'b1111; cfg_en = 1'b1;
    run_cycle(4, 17'h0_F00F, 3, 17'h0_F00F);
    set_off();
    cfg_spw = 2'b00; cfg_fsize = 4'b0000; cfg_en = 1'b1;
    run_cycle(4, 17'h1_2345, 3, 17'h1_2345);
    cfg_fsize = 4'b0100;
  endtask

  task automatic t_quiet();
    int act;
    set_off();
    cfg_spw = 2'b00; cfg_cont = 1'b1; cfg_en = 1'b1;
    run_cycle(4, 17'h0_0F0F, 3, 17'h0_0F0F);
    cfg_cont = 1'b0;
    run_cycle(4, 17'h1_1111, 2, 17'h1_1111);
    act = 0;
    for (int k = 0; k < 12; k++) begin
      if (line_oe) act++;
      @(negedge clk);
    end
    chk(act == 0, "R9", "idle after quiet stop", act, 0);
    periph_low = 1'b1;
    @(negedge clk);
    periph_low = 1'b0;
    run_cycle(3, 17'h0_8001, 2, 17'h0_8001);
    cfg_spw = 2'b10;
    @(negedge clk);
    periph_low = 1'b1;
    @(negedge clk);
    periph_low = 1'b0;
    run_cycle(7, 17'h0_0002, 2, 17'h0_0002);
  endtask

  task automatic t_abort();
    set_off();
    cfg_spw = 2'b00; cfg_cont = 1'b1; cfg_en = 1'b1;
    run_cycle(4, 17'h0_3C3C, 3, 17'h0_3C3C);
    periph_low = 1'b1;
    repeat (20) @(negedge clk);
    cfg_en = 1'b0;
    periph_low = 1'b0;
    @(negedge clk);
    chk(!line_oe, "R1", "no drive when disabled", line_oe, 0);
    chk(irq_lvl == '0, "R1", "irq inactive when disabled", int'(irq_lvl), 0);
    cfg_en = 1'b1;
    @(negedge clk);
    chk(irq_lvl == 17'h0_3C3C, "R10", "aborted cycle kept old levels",
        int'(irq_lvl), 'h3C3C);
    run_cycle(4, 17'h1_8000, 3, 17'h1_8000);
  endtask

  initial begin
    rst_n = 1'b0; cfg_en = 1'b0; cfg_cont = 1'b0;
    cfg_fsize = 4'b0100; cfg_spw = 2'b00; periph_low = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_cont();
    t_widths();
    t_quiet();
    t_abort();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule